// File: doc/BRIEF.md
# Three-Line Cascaded Delay Memory

This block stores a stream of pixel bytes in three equal-depth line buffers chained one after another, and presents the current line together with copies delayed by one and by two full lines. Vertical filters and other video operations use these three taps. The first buffer has its own write clock, an active-low write enable and an active-low write reset, so an incoming pixel stream can be captured at its own rate.

All reading is driven by one read clock with an active-low read enable and an active-low read reset. On every enabled read edge, each buffer presents the byte at its read address. In the same edge, the byte leaving each buffer is written into the next buffer down. The two lower buffers have no controls of their own. Their address counters advance only in step with the first buffer's read side.

Addresses step linearly and wrap from the last location back to zero. There are no full or empty flags. The three byte outputs are registered. A single enable output drives the pad tri-state control for all three outputs: it is high when reads are enabled and low when they are not.

Top module: `line_delay3`

## Requirements
- R1: With wr_en_ni low and wr_rst_ni high, a rising wclk_i edge stores din_i at the first buffer's write address, and that address steps by one.
- R2: With wr_en_ni high, a rising wclk_i edge stores nothing and the write address keeps its value.
- R3: With wr_rst_ni low, a rising wclk_i edge returns the first buffer's write address to zero. This takes priority over the write enable, and no byte is stored on that edge.
- R4: With rd_en_ni low and rd_rst_ni high, a rising rclk_i edge loads q0_o, q1_o and q2_o with the bytes at the read addresses of the first, second and third buffer. All three read addresses step by one, and oe_o is high after the edge.
- R5: On that same edge, the byte read from the first buffer is written into the second buffer, and the byte read from the second buffer is written into the third buffer. All read and downstream write addresses stay equal. As a result, q1_o repeats q0_o from DEPTH reads earlier, and q2_o repeats q0_o from 2*DEPTH reads earlier.
- R6: With rd_en_ni high, a rising rclk_i edge leaves all read and downstream write addresses unchanged. It writes nothing into the lower buffers, holds q0_o to q2_o, and drives oe_o low.
- R7: With rd_rst_ni low, a rising rclk_i edge returns all three read addresses and both downstream write addresses to zero. This takes priority over reading. No cascade write happens, q0_o to q2_o hold, and oe_o follows rd_en_ni.
- R8: Every address counter wraps from DEPTH-1 to zero, with no indication.
- R9: While rst_ni is low, all counters are zero, q0_o to q2_o are zero and oe_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock of the first buffer |
| rclk_i | input | 1 | Read and cascade clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the whole block |
| wr_rst_ni | input | 1 | Synchronous active-low clear of the write address |
| wr_en_ni | input | 1 | Active-low write enable |
| din_i | input | DW | Input pixel byte |
| rd_rst_ni | input | 1 | Synchronous active-low clear of read and cascade addresses |
| rd_en_ni | input | 1 | Active-low read enable |
| q0_o | output | DW | Current-line output |
| q1_o | output | DW | One-line delayed output |
| q2_o | output | DW | Two-line delayed output |
| oe_o | output | 1 | Pad drive enable for all three outputs; low means high impedance |

## Verification
A write takes effect at the wclk_i edge that samples it, and the stored byte becomes visible only when a later read reaches that address. The bench therefore checks writes through the read outputs rather than at write time. Each read, hold or read-reset step drives its controls, waits for the single rclk_i edge, and samples q0_o to q2_o and oe_o 1 ns later, so it sees exactly the one output register stage. The delay relations are checked by rewriting the first buffer with a distinct line between passes. The expected q1_o and q2_o values are then the bytes of the lines written one and two passes earlier, at the same address.

// File: rtl/line_delay3_pkg.sv
`timescale 1ns/1ps
package line_delay3_pkg;
  localparam int unsigned N_STAGE = 3;

  function automatic int unsigned addr_bits(input int unsigned depth);
    return (depth < 2) ? 1 : $clog2(depth);
  endfunction
endpackage

// File: rtl/ld_addr_ctr.sv
`timescale 1ns/1ps
module ld_addr_ctr #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_o <= '0;
    else if (clr_i)   addr_o <= '0;
    else if (inc_i)   addr_o <= (addr_o == LAST) ? '0 : addr_o + 1'b1;
  end
endmodule

// File: rtl/ld_line_ram.sv
`timescale 1ns/1ps
module ld_line_ram #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = 4
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  // asynchronous read; the caller registers the result
  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/line_delay3.sv
`timescale 1ns/1ps
module line_delay3
  import line_delay3_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = addr_bits(DEPTH)
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          wr_rst_ni,
  input  logic          wr_en_ni,
  input  logic [DW-1:0] din_i,
  input  logic          rd_rst_ni,
  input  logic          rd_en_ni,
  output logic [DW-1:0] q0_o,
  output logic [DW-1:0] q1_o,
  output logic [DW-1:0] q2_o,
  output logic          oe_o
);
  logic          wr_go, wr_clr, rd_go, rd_clr;
  logic [AW-1:0] wr_addr;
  logic [AW-1:0] rd_addr   [N_STAGE];
  logic [AW-1:0] cas_waddr [1:N_STAGE-1];
  logic [DW-1:0] rd_data   [N_STAGE];
  logic [DW-1:0] q_r       [N_STAGE];
  logic          oe_r;

  assign wr_clr = !wr_rst_ni;
  assign wr_go  = !wr_en_ni && wr_rst_ni;
  assign rd_clr = !rd_rst_ni;
  assign rd_go  = !rd_en_ni && rd_rst_ni;

  // head buffer: external write side
  ld_addr_ctr #(.DEPTH(DEPTH), .AW(AW)) u_wctr (
    .clk_i(wclk_i), .rst_ni(rst_ni), .clr_i(wr_clr), .inc_i(wr_go), .addr_o(wr_addr)
  );

  ld_addr_ctr #(.DEPTH(DEPTH), .AW(AW)) u_rctr0 (
    .clk_i(rclk_i), .rst_ni(rst_ni), .clr_i(rd_clr), .inc_i(rd_go), .addr_o(rd_addr[0])
  );

  ld_line_ram #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_ram0 (
    .wclk_i(wclk_i), .we_i(wr_go), .waddr_i(wr_addr), .wdata_i(din_i),
    .raddr_i(rd_addr[0]), .rdata_o(rd_data[0])
  );

  // cascaded buffers: written from the stage above on the read clock
  for (genvar s = 1; s < N_STAGE; s++) begin : g_stage
    ld_addr_ctr #(.DEPTH(DEPTH), .AW(AW)) u_rctr (
      .clk_i(rclk_i), .rst_ni(rst_ni), .clr_i(rd_clr), .inc_i(rd_go), .addr_o(rd_addr[s])
    );

    ld_addr_ctr #(.DEPTH(DEPTH), .AW(AW)) u_cwctr (
      .clk_i(rclk_i), .rst_ni(rst_ni), .clr_i(rd_clr), .inc_i(rd_go), .addr_o(cas_waddr[s])
    );

    // read-before-write: same address read and written on one edge
    ld_line_ram #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_ram (
      .wclk_i(rclk_i), .we_i(rd_go), .waddr_i(cas_waddr[s]), .wdata_i(rd_data[s-1]),
      .raddr_i(rd_addr[s]), .rdata_o(rd_data[s])
    );
  end

  for (genvar s = 0; s < N_STAGE; s++) begin : g_out
    always_ff @(posedge rclk_i or negedge rst_ni) begin
      if (!rst_ni)    q_r[s] <= '0;
      else if (rd_go) q_r[s] <= rd_data[s];
    end
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) oe_r <= 1'b0;
    else         oe_r <= !rd_en_ni;
  end

  assign q0_o = q_r[0];
  assign q1_o = q_r[1];
  assign q2_o = q_r[2];
  assign oe_o = oe_r;
endmodule

// File: rtl/line_delay3_chk.sv
`timescale 1ns/1ps
module line_delay3_chk #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = 4
) (
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          rst_ni,
  input logic          wr_rst_ni,
  input logic          wr_en_ni,
  input logic          rd_rst_ni,
  input logic          rd_en_ni,
  input logic [AW-1:0] wa_i,
  input logic [AW-1:0] ra0_i,
  input logic [AW-1:0] ra1_i,
  input logic [AW-1:0] ra2_i,
  input logic [AW-1:0] cwa1_i,
  input logic [AW-1:0] cwa2_i,
  input logic [DW-1:0] q0_i,
  input logic [DW-1:0] q1_i,
  input logic [DW-1:0] q2_i,
  input logic          oe_i
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  p_wr_step_r1: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (!wr_en_ni && wr_rst_ni && wa_i != LAST) |=> (wa_i == AW'($past(wa_i) + 1'b1)));

  p_wr_hold_r2: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wr_en_ni && wr_rst_ni) |=> $stable(wa_i));

  p_wr_clear_r3: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !wr_rst_ni |=> (wa_i == '0));

  p_oe_on_r4: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !rd_en_ni |=> oe_i);

  p_lockstep_r5: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (ra0_i == ra1_i) && (ra1_i == ra2_i) && (ra1_i == cwa1_i) && (ra2_i == cwa2_i));

  p_rd_hold_r6: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (rd_en_ni && rd_rst_ni) |=> ($stable(ra0_i) && $stable(q0_i) && $stable(q1_i) && $stable(q2_i)));

  p_oe_off_r6: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    rd_en_ni |=> !oe_i);

  p_rd_clear_r7: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !rd_rst_ni |=> (ra0_i == '0 && cwa1_i == '0 && cwa2_i == '0 &&
                    $stable(q0_i) && $stable(q1_i) && $stable(q2_i)));

  p_rd_wrap_r8: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!rd_en_ni && rd_rst_ni && ra0_i == LAST) |=> (ra0_i == '0));

  p_wr_wrap_r8: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (!wr_en_ni && wr_rst_ni && wa_i == LAST) |=> (wa_i == '0));

  always_comb begin
    if (!rst_ni) begin
      p_reset_r9: assert (wa_i == '0 && ra0_i == '0 && !oe_i);
    end
  end
endmodule

bind line_delay3 line_delay3_chk #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_chk (
  .wclk_i(wclk_i), .rclk_i(rclk_i), .rst_ni(rst_ni),
  .wr_rst_ni(wr_rst_ni), .wr_en_ni(wr_en_ni), .rd_rst_ni(rd_rst_ni), .rd_en_ni(rd_en_ni),
  .wa_i(wr_addr), .ra0_i(rd_addr[0]), .ra1_i(rd_addr[1]), .ra2_i(rd_addr[2]),
  .cwa1_i(cas_waddr[1]), .cwa2_i(cas_waddr[2]),
  .q0_i(q0_o), .q1_i(q1_o), .q2_i(q2_o), .oe_i(oe_o)
);

// File: tb/tb_line_delay3.sv
`timescale 1ns/1ps
module tb_line_delay3;
  localparam int D = 16;

  logic       wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic       wr_rst_n = 1'b1, wr_en_n = 1'b1, rd_rst_n = 1'b1, rd_en_n = 1'b1;
  logic [7:0] din = '0;
  logic [7:0] q0, q1, q2;
  logic       oe;
  int checks = 0, errors = 0;

  always #5 wclk = ~wclk;
  initial begin #3; forever #5 rclk = ~rclk; end

  line_delay3 #(.DW(8), .DEPTH(D)) dut (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n),
    .wr_rst_ni(wr_rst_n), .wr_en_ni(wr_en_n), .din_i(din),
    .rd_rst_ni(rd_rst_n), .rd_en_ni(rd_en_n),
    .q0_o(q0), .q1_o(q1), .q2_o(q2), .oe_o(oe)
  );

  function automatic logic [7:0] lv(input int p, input int i);
    return 8'((p * 37 + i * 11 + 5) & 255);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [7:0] d, input logic en_n, input logic rs_n);
    din = d; wr_en_n = en_n; wr_rst_n = rs_n;
    @(posedge wclk); #1;
    wr_en_n = 1'b1; wr_rst_n = 1'b1;
  endtask

  task automatic rd(input logic en_n, input logic rs_n);
    rd_en_n = en_n; rd_rst_n = rs_n;
    @(posedge rclk); #1;
  endtask

  task automatic write_line(input int p);
    for (int i = 0; i < D; i++) wr(lv(p, i), 1'b0, 1'b1);
  endtask

  // one full pass; lines p-1 and p-2 are expected on the delayed taps
  task automatic read_pass(input int p);
    for (int i = 0; i < D; i++) begin
      if (p == 0 && i == 7) begin
        rd(1'b1, 1'b1);
        chk("R6 oe low", {7'd0, oe}, 8'd0);
        chk("R6 q0 hold", q0, lv(0, 6));
      end
      rd(1'b0, 1'b1);
      chk((p >= 1 && i == 0) ? "R8 wrap q0" : "R4 q0", q0, lv(p, i));
      chk("R4 oe high", {7'd0, oe}, 8'd1);
      if (p >= 1) chk("R5 q1 one line", q1, lv(p - 1, i));
      if (p >= 2) chk("R5 q2 two lines", q2, lv(p - 2, i));
    end
    rd(1'b1, 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge rclk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #22;
    chk("R9 q0", q0, 8'd0);
    chk("R9 oe", {7'd0, oe}, 8'd0);
    @(negedge wclk); rst_n = 1'b1;
    @(negedge wclk);

    // R3: garbage, clear, then line 0 with one disabled cycle (R2)
    for (int i = 0; i < 3; i++) wr(8'hAA, 1'b0, 1'b1);
    wr(8'h55, 1'b0, 1'b0);
    for (int i = 0; i < D; i++) begin
      if (i == 5) wr(8'hEE, 1'b1, 1'b1);
      wr(lv(0, i), 1'b0, 1'b1);   // R1
    end
    read_pass(0);
    chk("R6 oe idle", {7'd0, oe}, 8'd0);

    for (int p = 1; p < 3; p++) begin
      write_line(p);
      read_pass(p);
    end

    // R7: read reset part way through a pass
    write_line(3);
    for (int i = 0; i < D / 2; i++) begin
      rd(1'b0, 1'b1);
      chk("R4 q0", q0, lv(3, i));
      chk("R5 q1", q1, lv(2, i));
      chk("R5 q2", q2, lv(1, i));
    end
    rd(1'b0, 1'b0);
    chk("R7 q0 hold", q0, lv(3, D / 2 - 1));
    chk("R7 q1 hold", q1, lv(2, D / 2 - 1));
    chk("R7 q2 hold", q2, lv(1, D / 2 - 1));
    chk("R7 oe", {7'd0, oe}, 8'd1);
    for (int i = 0; i < D; i++) begin
      rd(1'b0, 1'b1);
      chk("R7 q0 restart", q0, lv(3, i));
      chk("R7 q1 restart", q1, (i < D / 2) ? lv(3, i) : lv(2, i));
      chk("R7 q2 restart", q2, (i < D / 2) ? lv(2, i) : lv(1, i));
    end
    rd(1'b1, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule